// File: doc/BRIEF.md
# CEC Transmit Frame Staging Registers

This block is a small register file that software fills with one CEC frame before sending it. A simple write/read port carries byte data at word-aligned byte addresses. Software writes the initiator, the destination, an opcode, up to fourteen operand bytes and a retry limit. It then launches the frame, and the block presents the full frame descriptor to a downstream line engine. The line engine drives the bus bits and answers each attempt with an acknowledge or a negative acknowledge.

The block re-launches a negatively acknowledged frame until the programmed number of attempts is used up. It records the result in sticky status bits that software clears by writing 1. An interrupt line combines those bits with enable registers. A header-only polling frame is launched by the destination write alone. A self-clearing clear bit empties the staging buffer.

Register map (byte addresses): 0x00 control (bit 7 clear, bits 6:4 retry field), 0x04 initiator [3:0], 0x08 destination [3:0] with bit 7 = polling launch, 0x0C status A (bit 5 = sent OK), 0x10 status B (bit 1 = retries exhausted), 0x14 enable A, 0x18 enable B, 0x1C state (bit 0 = busy), 0x20 opcode, 0x24 + 4·i operand i (i = 0..13), 0x5C launch (bits 3:0 operand count, bit 4 = go).

Top module: `cec_tx_stage`

## Requirements
- R1: After reset every register reads 0, `busy` is 0, `launch` is 0 and `irq` is 0.
- R2: A write to 0x5C with bit 4 set makes the block busy and raises `launch` for exactly one cycle after the write edge. The descriptor then carries the stored initiator, destination, opcode and operands, with `f_poll`=0 and `f_nops` equal to bits 3:0 of the write.
- R3: An operand count above 14 is presented on `f_nops` as 14.
- R4: A write to 0x08 with bit 7 set launches a header-only frame: `f_poll`=1, `f_nops`=0, and `f_dest` equal to the low 4 bits written.
- R5: An acknowledged attempt (`eng_done` with `eng_ack`=1) clears busy and sets bit 5 of status A (0x0C reads 0x20).
- R6: A negatively acknowledged attempt re-launches the frame while fewer than the retry field value of retries have been made. The frame gets retry field + 1 launches in total. The last refusal clears busy and sets bit 1 of status B (0x10 reads 0x02).
- R7: After retries are exhausted, bits 6:4 of 0x00 read the number of retries made, until a clear or a new launch.
- R8: Writing 0x00 with bit 7 set makes bit 7 read 1 for one cycle and then 0. It also zeroes the opcode and operand registers and drops the exhaustion readback.
- R9: Status bits are sticky. Writing 0 to them has no effect; writing 1 clears them.
- R10: While busy, writes to control, initiator, destination, opcode, operands and launch are ignored, and 0x1C bit 0 reads 1.
- R11: `irq` is high when (status A bit 5 AND enable A bit 5) OR (status B bit 1 AND enable B bit 1).
- R12: Operand i reads back at byte address 0x24 + 4·i, and the last operand (0x58) is independent of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Byte address, word aligned |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| launch | output | 1 | One-cycle pulse per transmit attempt |
| busy | output | 1 | Frame in flight |
| f_init | output | 4 | Initiator address |
| f_dest | output | 4 | Destination address |
| f_poll | output | 1 | Header-only frame |
| f_opcode | output | 8 | Opcode byte |
| f_nops | output | 4 | Operand count |
| f_ops | output | 112 | Operand bytes, operand i at bits 8i+7:8i |
| eng_done | input | 1 | Line engine finished an attempt |
| eng_ack | input | 1 | Attempt acknowledged when 1 |
| irq | output | 1 | Enabled status interrupt |

## Verification
The bench aims at the retry boundary. A design that is off by one in its retry comparison launches one attempt too many or too few, or raises exhaustion while still busy. It also tests writes made during a frame: a design that lets them through corrupts the opcode readback or launches a second time. It checks that writing 0 to status changes nothing, because a design that clears on any write loses the interrupt. It also checks the one-cycle life of the clear bit, the clamp of an operand count of 15, and the polling launch. A wrong polling launch would report operands or need a launch write.

// File: rtl/cec_tx_stage.sv
module cec_tx_stage #(
  parameter int NOPS = 14,
  parameter int AW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            launch,
  output logic            busy,
  output logic [3:0]      f_init,
  output logic [3:0]      f_dest,
  output logic            f_poll,
  output logic [7:0]      f_opcode,
  output logic [3:0]      f_nops,
  output logic [NOPS*8-1:0] f_ops,
  input  logic            eng_done,
  input  logic            eng_ack,
  output logic            irq
);
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h00);
  localparam logic [AW-1:0] A_INIT  = AW'(8'h04);
  localparam logic [AW-1:0] A_DEST  = AW'(8'h08);
  localparam logic [AW-1:0] A_STA   = AW'(8'h0C);
  localparam logic [AW-1:0] A_STB   = AW'(8'h10);
  localparam logic [AW-1:0] A_ENA   = AW'(8'h14);
  localparam logic [AW-1:0] A_ENB   = AW'(8'h18);
  localparam logic [AW-1:0] A_STATE = AW'(8'h1C);
  localparam logic [AW-1:0] A_OPC   = AW'(8'h20);
  localparam logic [AW-1:0] A_OP0   = AW'(8'h24);
  localparam logic [AW-1:0] A_GO    = A_OP0 + AW'(4 * NOPS);
  localparam logic [3:0]    MAXN    = 4'(NOPS);

  logic [3:0] init_q, dest_q, cnt_q;
  logic       poll_q, busy_q, launch_q, clr_pend, ex_hold;
  logic [7:0] opc_q, ena_q, enb_q;
  logic [7:0] ops_q [NOPS];
  logic [2:0] lim_q, tries_q;
  logic       ok_st, ex_st;

  logic [AW-1:0] off;
  logic          op_hit;
  logic [AW-3:0] op_idx;
  assign off    = addr - A_OP0;
  assign op_hit = (addr >= A_OP0) && (addr < A_GO) && (addr[1:0] == 2'b00);
  assign op_idx = off[AW-1:2];

  logic stage_ok, go_data, go_poll, go_any, ok_done, nack, give_up;
  assign stage_ok = wr_en & ~busy_q;
  assign go_data  = stage_ok && addr == A_GO && wdata[4];
  assign go_poll  = stage_ok && addr == A_DEST && wdata[7];
  assign go_any   = go_data | go_poll;
  assign ok_done  = busy_q & eng_done & eng_ack;
  assign nack     = busy_q & eng_done & ~eng_ack;
  assign give_up  = nack && (tries_q == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0; dest_q <= '0; cnt_q <= '0; poll_q <= 1'b0;
      opc_q <= '0; lim_q <= '0; tries_q <= '0; ex_hold <= 1'b0;
      busy_q <= 1'b0; launch_q <= 1'b0; clr_pend <= 1'b0;
      for (int i = 0; i < NOPS; i++) ops_q[i] <= '0;
    end else begin
      launch_q <= 1'b0;
      if (clr_pend) begin
        clr_pend <= 1'b0;
        opc_q    <= '0;
        ex_hold  <= 1'b0;
        tries_q  <= '0;
        for (int i = 0; i < NOPS; i++) ops_q[i] <= '0;
      end
      if (stage_ok) begin
        if (addr == A_CTRL) begin
          lim_q    <= wdata[6:4];
          clr_pend <= wdata[7];
        end
        if (addr == A_INIT) init_q <= wdata[3:0];
        if (addr == A_DEST) dest_q <= wdata[3:0];
        if (addr == A_OPC)  opc_q  <= wdata;
        if (op_hit)         ops_q[op_idx] <= wdata;
      end
      if (go_any) begin
        busy_q   <= 1'b1;
        launch_q <= 1'b1;
        poll_q   <= go_poll;
        cnt_q    <= go_poll ? 4'd0 : (wdata[3:0] > MAXN ? MAXN : wdata[3:0]);
        tries_q  <= '0;
        ex_hold  <= 1'b0;
      end
      if (ok_done) busy_q <= 1'b0;
      if (nack) begin
        if (give_up) begin
          busy_q  <= 1'b0;
          ex_hold <= 1'b1;
        end else begin
          tries_q  <= tries_q + 3'd1;
          launch_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_st <= 1'b0; ex_st <= 1'b0; ena_q <= '0; enb_q <= '0;
    end else begin
      if (wr_en && addr == A_STA && wdata[5]) ok_st <= 1'b0;
      if (wr_en && addr == A_STB && wdata[1]) ex_st <= 1'b0;
      if (wr_en && addr == A_ENA) ena_q <= wdata;
      if (wr_en && addr == A_ENB) enb_q <= wdata;
      if (ok_done) ok_st <= 1'b1;
      if (give_up) ex_st <= 1'b1;
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      A_CTRL:  rdata = {clr_pend, ex_hold ? tries_q : lim_q, 4'h0};
      A_INIT:  rdata = {4'h0, init_q};
      A_DEST:  rdata = {4'h0, dest_q};
      A_STA:   rdata = {2'b00, ok_st, 5'b0};
      A_STB:   rdata = {6'b0, ex_st, 1'b0};
      A_ENA:   rdata = ena_q;
      A_ENB:   rdata = enb_q;
      A_STATE: rdata = {7'b0, busy_q};
      A_OPC:   rdata = opc_q;
      A_GO:    rdata = {4'h0, cnt_q};
      default: if (op_hit) rdata = ops_q[op_idx];
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NOPS; g++) begin : g_ops
      assign f_ops[g*8 +: 8] = ops_q[g];
    end
  endgenerate

  assign launch   = launch_q;
  assign busy     = busy_q;
  assign f_init   = init_q;
  assign f_dest   = dest_q;
  assign f_poll   = poll_q;
  assign f_opcode = opc_q;
  assign f_nops   = cnt_q;
  assign irq      = (ok_st & ena_q[5]) | (ex_st & enb_q[1]);

  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> busy);
  assert_poll_no_ops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && f_poll) |-> (f_nops == 4'd0));
  assert_nops_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    f_nops <= MAXN);
  assert_ack_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done && eng_ack) |=> (!busy && ok_st));
  assert_exhaust_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ex_st) |-> !busy);
  assert_tries_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tries_q <= lim_q));
  assert_clear_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> !clr_pend);
  assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> ($stable(opc_q) && $stable(f_init) && $stable(f_dest)));
endmodule

// File: tb/cec_tx_stage_tb_top.sv
module cec_tx_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NOPS = 14;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, eng_done = 1'b0, eng_ack = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic launch, busy, f_poll, irq;
  logic [3:0] f_init, f_dest, f_nops;
  logic [7:0] f_opcode;
  logic [NOPS*8-1:0] f_ops;

  int n_chk = 0, n_bad = 0, n_launch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cec_tx_stage #(.NOPS(NOPS), .AW(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .launch(launch), .busy(busy), .f_init(f_init), .f_dest(f_dest),
    .f_poll(f_poll), .f_opcode(f_opcode), .f_nops(f_nops), .f_ops(f_ops),
    .eng_done(eng_done), .eng_ack(eng_ack), .irq(irq));

  always @(posedge clk) if (rst_n && launch) n_launch++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic resp(input logic ack);
    @(negedge clk); eng_done = 1'b1; eng_ack = ack;
    @(negedge clk); eng_done = 1'b0; eng_ack = 1'b0;
  endtask

  typedef struct packed { logic [7:0] a; logic [7:0] d; logic [7:0] e; } vec_t;
  localparam vec_t VECS [8] = '{
    '{8'h04, 8'h3C, 8'h0C}, '{8'h08, 8'h24, 8'h04}, '{8'h20, 8'h9A, 8'h9A},
    '{8'h14, 8'hFF, 8'hFF}, '{8'h18, 8'h02, 8'h02}, '{8'h24, 8'h11, 8'h11},
    '{8'h58, 8'hEE, 8'hEE}, '{8'h00, 8'h30, 8'h30}};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h1C, v); chk("R1 busy reg", v, 0);
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h0C, v); chk("R1 status A", v, 0);
    chk("R1 irq/launch", {irq, launch}, 0);

    // R12 table of register write/readback
    for (int i = 0; i < 8; i++) begin
      wr(VECS[i].a[6:0], VECS[i].d);
      rd(VECS[i].a[6:0], v);
      chk($sformatf("R12 vec %0d", i), v, VECS[i].e);
    end
    rd(8'h24, v); chk("R12 first op independent of last", v, 8'h11);

    // R2 data launch with 3 operands
    wr(8'h24, 8'hA1); wr(8'h28, 8'hB2); wr(8'h2C, 8'hC3);
    base = n_launch;
    wr(8'h5C, 8'h13);
    chk("R2 busy/launch", {busy, launch}, 2'b11);
    chk("R2 nops", f_nops, 3);
    chk("R2 poll", f_poll, 0);
    chk("R2 header", {f_init, f_dest, f_opcode}, {4'hC, 4'h4, 8'h9A});
    chk("R2 ops", f_ops[23:0], 24'hC3B2A1);
    // R10 writes ignored while busy
    wr(8'h20, 8'h55); wr(8'h5C, 8'h12);
    rd(8'h20, v); chk("R10 opcode held", v, 8'h9A);
    rd(8'h1C, v); chk("R10 busy readable", v, 1);
    chk("R2 single launch", n_launch - base, 1);

    // R5 acknowledge
    resp(1'b1);
    chk("R5 busy clear", busy, 0);
    rd(8'h0C, v); chk("R5 status A", v, 8'h20);
    chk("R11 irq on A", irq, 1);
    // R9 sticky / W1C
    wr(8'h0C, 8'h00); rd(8'h0C, v); chk("R9 write 0 no effect", v, 8'h20);
    wr(8'h0C, 8'h20); rd(8'h0C, v); chk("R9 write 1 clears", v, 0);
    chk("R11 irq low", irq, 0);

    // R6 retries: field 3 -> 4 attempts
    wr(8'h00, 8'h30);
    base = n_launch;
    wr(8'h5C, 8'h10);
    for (int k = 0; k < 3; k++) resp(1'b0);
    @(negedge clk);
    chk("R6 still busy before last", busy, 1);
    rd(8'h10, v); chk("R6 no exhaust yet", v, 0);
    resp(1'b0);
    @(negedge clk);
    chk("R6 launches", n_launch - base, 4);
    chk("R6 idle after exhaust", busy, 0);
    rd(8'h10, v); chk("R6 status B", v, 8'h02);
    rd(8'h00, v); chk("R7 retries made", v[6:4], 3);
    chk("R11 irq on B", irq, 1);
    wr(8'h10, 8'h02); chk("R11 irq cleared", irq, 0);

    // R8 clear
    wr(8'h00, 8'h80);
    rd(8'h00, v); chk("R8 clear bit set", v[7], 1);
    @(negedge clk);
    rd(8'h00, v); chk("R8 clear self-resets", v, 0);
    rd(8'h20, v); chk("R8 opcode zeroed", v, 0);
    rd(8'h24, v); chk("R8 operand zeroed", v, 0);

    // R4 polling frame
    base = n_launch;
    wr(8'h08, 8'h87);
    chk("R4 poll launch", {busy, f_poll, f_nops, f_dest}, {1'b1, 1'b1, 4'd0, 4'h7});
    resp(1'b1);
    chk("R4 single launch", n_launch - base, 1);

    // R3 count clamp
    wr(8'h5C, 8'h1F);
    chk("R3 nops clamped", f_nops, 14);
    resp(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule